// File: doc/BRIEF.md
# Receive Character Queue with Error Tags and Idle Timeout

This block sits between a serial deserializer and a host register interface. Each character that the deserializer finishes arrives with a one-cycle strobe, together with eight data bits and three error tags. The block stores them as 11-bit entries in a first-in first-out queue of `DEPTH` entries. The oldest stored character is always visible to the host on a read-only holding output, and its tags are shown beside it as status bits. A single host read strobe removes that head entry, and the next entry's data and tags become visible at once.

The block raises a data-ready interrupt in one of two ways: on every stored character, or only once the fill level reaches a trigger threshold selected by a two-bit field. An idle timer counts bit-time ticks while characters are waiting. When the line has been quiet for four word lengths plus twelve bit times, it raises a timeout interrupt, so that a few trailing characters below the trigger threshold still reach the host. A mode bit can turn the queue into a single-entry holding buffer. A character that finds no free space is discarded, and this is recorded in a sticky overrun flag.

Top module: `rx_char_buffer`

## Requirements
- R1: Characters are stored in arrival order as 8 data bits plus 3 tags, up to `DEPTH` (64) entries when `cfg_fifo_en`=1. `hold_data` and `hold_tags` show the oldest stored entry.
- R2: A `rd_strobe` while the queue is not empty removes the head entry. From the clock edge that samples the strobe, `hold_data` and `hold_tags` show the next entry.
- R3: When `cfg_fifo_en`=0, the capacity is one entry: a second character arriving before the first is read is discarded.
- R4: A `char_valid` that arrives while the queue is at capacity is discarded and sets `overrun`. `overrun` stays set until a `status_rd` strobe clears it. A new overrun in the same cycle as the clear wins.
- R5: `data_ready` is 1 exactly when at least one entry is stored. While the queue is empty, `hold_data` and `hold_tags` read 0.
- R6: In threshold mode (`cfg_irq_each`=0, `cfg_fifo_en`=1), `rx_irq` is 1 when `level` is at least the threshold. The threshold is set by `cfg_trig_sel`: 0 selects 8, 1 selects 16, 2 selects 56 and 3 selects 60 entries (DEPTH/8, DEPTH/4, DEPTH-DEPTH/8, DEPTH-DEPTH/16).
- R7: With `cfg_irq_each`=1, or with `cfg_fifo_en`=0, `rx_irq` is 1 whenever at least one entry is stored.
- R8: With `cfg_rx_irq_en`=0, both `rx_irq` and `timeout_irq` stay 0.
- R9: `timeout_irq` rises on the clock edge that samples the N-th `bit_tick` with no intervening character strobe or host read while data is stored, where N = 4*(5+`cfg_len_sel`) + 12.
- R10: Every `char_valid` strobe and every `rd_strobe` restarts the idle count. A read that removes an entry, or an empty queue, clears a pending timeout.
- R11: `level` gives the number of stored entries. It changes on the edge that samples a stored character (+1) or a removal (-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a character is complete |
| char_data | input | 8 | Received data bits |
| char_tags | input | 3 | Error tags of the received character |
| bit_tick | input | 1 | One pulse per bit time |
| rd_strobe | input | 1 | Host read of the holding output |
| status_rd | input | 1 | Host read of status; clears overrun |
| cfg_fifo_en | input | 1 | 1: full-depth queue, 0: single-entry buffer |
| cfg_irq_each | input | 1 | 1: interrupt on every character |
| cfg_trig_sel | input | 2 | Threshold select |
| cfg_len_sel | input | 2 | Word length minus five |
| cfg_rx_irq_en | input | 1 | Enables both receive interrupts |
| hold_data | output | 8 | Head character data |
| hold_tags | output | 3 | Head character tags |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky discard flag |
| rx_irq | output | 1 | Data-ready interrupt |
| timeout_irq | output | 1 | Idle timeout interrupt |
| level | output | 7 | Number of stored entries |

## Verification
All outputs come from registers that update on the edge sampling a strobe or tick. Level, head data, tags, data-ready, the interrupts and overrun are therefore due one edge after the stimulus, and rx_irq also responds at once to a configuration change. The bench drives every strobe for one cycle starting at a falling edge and samples at the next falling edge, half a cycle after the edge that updates the registers. For the timeout, it applies exactly N-1 ticks and checks that the output is still low, then applies the N-th tick and checks that it has risen. It repeats this for each word-length setting.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W  = 8;
  localparam int TAG_W   = 3;
  localparam int ENTRY_W = DATA_W + TAG_W;
  localparam int IDLE_W  = 6;

  typedef struct packed {
    logic [TAG_W-1:0]  tags;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  // threshold in entries for a given select code and queue depth
  function automatic int trig_entries(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    return depth / 8;
      2'd1:    return depth / 4;
      2'd2:    return depth - depth / 8;
      default: return depth - depth / 16;
    endcase
  endfunction

  // quiet period in bit times: four words plus twelve bits
  function automatic logic [IDLE_W-1:0] idle_bits(input logic [1:0] len_sel);
    return IDLE_W'(4 * (5 + int'(len_sel)) + 12);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 64,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage array: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assign rdata = (cnt_q != '0) ? mem[rd_q] : '0;
  assign count = cnt_q;
endmodule

// File: rtl/rxq_trigger.sv
module rxq_trigger #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic          irq_each,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  output logic          rx_irq
);
  logic [CW-1:0] thr [4];
  logic          reached;

  for (genvar g = 0; g < 4; g++) begin : g_thr
    assign thr[g] = CW'(rxq_pkg::trig_entries(2'(g), DEPTH));
  end

  always_comb begin
    if (!fifo_en || irq_each) reached = (count != '0);
    else                      reached = (count >= thr[trig_sel]);
  end

  assign rx_irq = irq_en && reached;
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          flush,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (flush) begin
      cnt_d  = '0;
      flag_d = 1'b0;
    end else if (restart) begin
      cnt_d = '0;
    end else if (tick && !flag_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q + 1'b1 == limit) flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign expired = flag_q;
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          char_valid,
  input  logic [rxq_pkg::DATA_W-1:0]    char_data,
  input  logic [rxq_pkg::TAG_W-1:0]     char_tags,
  input  logic                          bit_tick,
  input  logic                          rd_strobe,
  input  logic                          status_rd,
  input  logic                          cfg_fifo_en,
  input  logic                          cfg_irq_each,
  input  logic [1:0]                    cfg_trig_sel,
  input  logic [1:0]                    cfg_len_sel,
  input  logic                          cfg_rx_irq_en,
  output logic [rxq_pkg::DATA_W-1:0]    hold_data,
  output logic [rxq_pkg::TAG_W-1:0]     hold_tags,
  output logic                          data_ready,
  output logic                          overrun,
  output logic                          rx_irq,
  output logic                          timeout_irq,
  output logic [CW-1:0]                 level
);
  import rxq_pkg::*;

  rx_entry_t     wr_entry, head;
  logic [CW-1:0] count;
  logic          full, push, pop, empty;
  logic          ovr_q, ovr_d;
  logic          idle_hit;

  assign empty = (count == '0);
  assign full  = cfg_fifo_en ? (count >= CW'(DEPTH)) : !empty;
  assign push  = char_valid && !full;
  assign pop   = rd_strobe && !empty;

  assign wr_entry.data = char_data;
  assign wr_entry.tags = char_tags;

  rxq_store #(.DEPTH(DEPTH), .W(ENTRY_W)) store_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .wdata (wr_entry),
    .rdata (head),
    .count (count)
  );

  rxq_trigger #(.DEPTH(DEPTH)) trig_i (
    .count    (count),
    .fifo_en  (cfg_fifo_en),
    .irq_each (cfg_irq_each),
    .trig_sel (cfg_trig_sel),
    .irq_en   (cfg_rx_irq_en),
    .rx_irq   (rx_irq)
  );

  rxq_idle_timer #(.TW(IDLE_W)) idle_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (bit_tick),
    .restart (char_valid || rd_strobe),
    .flush   (empty || pop),
    .limit   (idle_bits(cfg_len_sel)),
    .expired (idle_hit)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (char_valid && full) ovr_d = 1'b1;
    else if (status_rd)     ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign hold_data   = head.data;
  assign hold_tags   = head.tags;
  assign data_ready  = !empty;
  assign overrun     = ovr_q;
  assign timeout_irq = cfg_rx_irq_en && idle_hit;
  assign level       = count;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          char_valid,
  input logic          rd_strobe,
  input logic          cfg_fifo_en,
  input logic          cfg_rx_irq_en,
  input logic [2:0]    hold_tags,
  input logic          overrun,
  input logic          rx_irq,
  input logic          timeout_irq,
  input logic [CW-1:0] level
);
  logic at_cap;
  assign at_cap = cfg_fifo_en ? (int'(level) >= DEPTH) : (level != '0);

  p_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);

  p_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && !rd_strobe && !at_cap |=> int'(level) == int'($past(level)) + 1);

  p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !char_valid && level != '0 |=> int'(level) == int'($past(level)) - 1);

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid && at_cap |=> overrun && level == $past(level) - CW'(rd_strobe));

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en |-> level <= CW'(1) || $past(level) > CW'(1));

  p_empty_tags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level == '0 |-> hold_tags == '0);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx_irq_en |-> !rx_irq && !timeout_irq);

  p_tmo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && level != '0 |=> !timeout_irq);
endmodule

bind rx_char_buffer rxq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .char_valid    (char_valid),
  .rd_strobe     (rd_strobe),
  .cfg_fifo_en   (cfg_fifo_en),
  .cfg_rx_irq_en (cfg_rx_irq_en),
  .hold_tags     (hold_tags),
  .overrun       (overrun),
  .rx_irq        (rx_irq),
  .timeout_irq   (timeout_irq),
  .level         (level)
);

// File: tb/rx_char_buffer_tb.sv
`timescale 1ns/1ps
module rx_char_buffer_tb_top;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_valid = 1'b0, bit_tick = 1'b0, rd_strobe = 1'b0, status_rd = 1'b0;
  logic [7:0] char_data = '0;
  logic [2:0] char_tags = '0;
  logic       cfg_fifo_en = 1'b1, cfg_irq_each = 1'b0, cfg_rx_irq_en = 1'b1;
  logic [1:0] cfg_trig_sel = '0, cfg_len_sel = '0;
  logic [7:0] hold_data;
  logic [2:0] hold_tags;
  logic       data_ready, overrun, rx_irq, timeout_irq;
  logic [6:0] level;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_char_buffer #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_tags(char_tags), .bit_tick(bit_tick), .rd_strobe(rd_strobe),
    .status_rd(status_rd), .cfg_fifo_en(cfg_fifo_en), .cfg_irq_each(cfg_irq_each),
    .cfg_trig_sel(cfg_trig_sel), .cfg_len_sel(cfg_len_sel), .cfg_rx_irq_en(cfg_rx_irq_en),
    .hold_data(hold_data), .hold_tags(hold_tags), .data_ready(data_ready),
    .overrun(overrun), .rx_irq(rx_irq), .timeout_irq(timeout_irq), .level(level)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one-cycle strobes starting at a falling edge; results sampled at the next falling edge
  task automatic put(input logic [7:0] d, input logic [2:0] t);
    @(negedge clk); char_valid = 1'b1; char_data = d; char_tags = t;
    @(negedge clk); char_valid = 1'b0;
  endtask
  task automatic take();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask
  task automatic stat();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
  endtask

  function automatic logic [7:0] pat_d(input int i); return 8'((i * 37 + 5) % 256); endfunction
  function automatic logic [2:0] pat_t(input int i); return 3'(i % 8); endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int thr_tab[4];
    int base;
    thr_tab = '{8, 16, 56, 60};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset ready", int'(data_ready), 0);
    check("R11 reset level", int'(level), 0);
    check("R4 reset overrun", int'(overrun), 0);
    check("R5 reset data", int'(hold_data), 0);

    // threshold sweep, full-queue discard and ordered drain
    base = 0;
    for (int s = 0; s < 4; s++) begin
      cfg_trig_sel = 2'(s);
      for (int i = 0; i < DEPTH; i++) begin
        put(pat_d(base + i), pat_t(base + i));
        check("R11 level fill", int'(level), i + 1);
        check("R6 threshold irq", int'(rx_irq), int'(i + 1 >= thr_tab[s]));
        check("R1 head stays oldest", int'(hold_data), int'(pat_d(base)));
      end
      put(8'hEE, 3'd7);
      check("R4 discard level", int'(level), DEPTH);
      check("R4 overrun set", int'(overrun), 1);
      check("R1 head after discard", int'(hold_data), int'(pat_d(base)));
      stat();
      check("R4 overrun cleared", int'(overrun), 0);
      for (int i = 0; i < DEPTH; i++) begin
        check("R1 head data", int'(hold_data), int'(pat_d(base + i)));
        check("R2 head tags", int'(hold_tags), int'(pat_t(base + i)));
        check("R5 ready", int'(data_ready), 1);
        take();
        check("R11 level drain", int'(level), DEPTH - 1 - i);
      end
      check("R5 empty ready", int'(data_ready), 0);
      check("R5 empty tags", int'(hold_tags), 0);
      base += DEPTH + 3;
    end

    // overrun set wins over a simultaneous clear
    for (int i = 0; i < DEPTH; i++) put(8'(i), 3'd0);
    @(negedge clk); char_valid = 1'b1; status_rd = 1'b1;
    @(negedge clk); char_valid = 1'b0; status_rd = 1'b0;
    check("R4 set wins", int'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) take();
    stat();

    // each-character mode and the enable gate
    cfg_trig_sel = 2'd3; cfg_irq_each = 1'b1;
    put(8'h11, 3'd5);
    check("R7 each mode irq", int'(rx_irq), 1);
    check("R2 tags visible", int'(hold_tags), 5);
    cfg_rx_irq_en = 1'b0;
    @(negedge clk);
    check("R8 gated irq", int'(rx_irq), 0);
    ticks(32);
    check("R8 gated timeout", int'(timeout_irq), 0);
    cfg_rx_irq_en = 1'b1;
    @(negedge clk);
    check("R8 timeout shows when enabled", int'(timeout_irq), 1);
    take();
    check("R10 read clears timeout", int'(timeout_irq), 0);
    cfg_irq_each = 1'b0;

    // single-entry mode
    cfg_fifo_en = 1'b0;
    put(8'hA5, 3'd2);
    check("R7 single mode irq", int'(rx_irq), 1);
    put(8'h5A, 3'd4);
    check("R3 single capacity", int'(level), 1);
    check("R3 first kept", int'(hold_data), 8'hA5);
    check("R4 single overrun", int'(overrun), 1);
    take();
    check("R3 empty after read", int'(data_ready), 0);
    put(8'h3C, 3'd1);
    check("R3 accepts again", int'(hold_data), 8'h3C);
    take(); stat();
    cfg_fifo_en = 1'b1;

    // timeout threshold per word length, restart and clear
    for (int l = 0; l < 4; l++) begin
      int n;
      n = 4 * (5 + l) + 12;
      cfg_len_sel = 2'(l);
      put(8'(l), 3'd0);
      ticks(n - 1);
      check("R9 before limit", int'(timeout_irq), 0);
      ticks(1);
      check("R9 at limit", int'(timeout_irq), 1);
      put(8'(l + 8), 3'd0);
      check("R10 char keeps pending", int'(timeout_irq), 1);
      take();
      check("R10 read clears", int'(timeout_irq), 0);
      ticks(n - 1);
      check("R10 restart after read", int'(timeout_irq), 0);
      put(8'(l + 16), 3'd0);
      ticks(n - 1);
      check("R10 restart after char", int'(timeout_irq), 0);
      ticks(1);
      check("R9 after restart", int'(timeout_irq), 1);
      take(); take();
      check("R10 empty clears", int'(timeout_irq), 0);
      ticks(n + 2);
      check("R10 empty no timeout", int'(timeout_irq), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule